// File: doc/BRIEF.md
# Compact Extend and Jump Unit

This unit executes one group of 16-bit compact instructions that share a single major opcode. The group holds six in-place extend operations, which take the low byte, halfword or word of one register and widen it with zeros or with its sign bit, and three register jumps that take effect without a delay slot. One of the jumps also saves a link address.

The pipeline presents an instruction with an issue strobe, together with the value already read from the addressed register, the current return-address register value, the address of the next instruction and a flag that says whether 64-bit operations are enabled. One clock later the unit reports what the instruction does: a register write-back, a return-address write, a redirect target, or an illegal-instruction flag. The register file, fetch and hazard handling sit outside the unit. The data path width is a parameter of 32 or 64 bits.

Top module: `compact_xj_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: If issue is low, or if instruction bits 15:11 are not 11101, the next cycle shows no write-back, no return-address write, no redirect and no illegal flag.
- R3: With funct (bits 4:0) 10001, sub-operation (bits 7:5) 000 writes back the low 8 bits zero-extended, and 001 writes back the low 16 bits zero-extended.
- R4: With funct 10001, sub-operation 100 writes back the low 8 bits sign-extended, and 101 writes back the low 16 bits sign-extended.
- R5: In a 64-bit build with the mode flag high, sub-operation 010 writes back the low 32 bits zero-extended, and 110 writes back the low 32 bits sign-extended.
- R6: A word extend (sub-operation 010 or 110) raises the illegal flag and writes nothing when the mode flag is low or the build is 32 bits wide.
- R7: Register field values 0 to 7 (bits 10:8) select write-back indices 16, 17, 2, 3, 4, 5, 6 and 7.
- R8: With funct 00000 and sub-operation 100, the unit redirects to the addressed register value and writes no register.
- R9: With funct 00000, sub-operation 101 and register field 000, the unit redirects to the return-address value and writes no register.
- R10: With funct 00000 and sub-operation 110, the unit writes the next-instruction address to the return-address register and redirects to the addressed register value.
- R11: Every other funct and sub-operation pair in the group, including sub-operation 101 with a nonzero register field, raises the illegal flag with no write and no redirect.
- R12: Results appear in the cycle after the issue cycle and last one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction presented this cycle |
| instr_i | input | 16 | Compact instruction word |
| rx_val_i | input | XLEN | Value of the addressed register |
| ra_val_i | input | XLEN | Current return-address register value |
| next_pc_i | input | XLEN | Address of the following instruction |
| mode64_i | input | 1 | 64-bit operations enabled |
| wb_en_o | output | 1 | Register write-back enable |
| wb_idx_o | output | 5 | Architectural register to write |
| wb_data_o | output | XLEN | Write-back data |
| ra_we_o | output | 1 | Return-address register write enable |
| ra_data_o | output | XLEN | Return-address write data |
| redir_o | output | 1 | Redirect fetch this cycle |
| redir_tgt_o | output | XLEN | Redirect target |
| illegal_o | output | 1 | Illegal-instruction flag |

## Verification
The extends get register values whose sign bits at positions 7, 15 and 31 are set in some patterns and clear in others. This separates a sign fill from a zero fill and shows that each width cuts at the right bit. The word extends run with the mode flag high and low, which separates a legal write from an illegal trap. The jumps get distinct register, return-address and next-address values, so a target taken from the wrong source stands out. Encodings next to the legal ones, and words from outside the group, show whether the decode is too loose.

// File: rtl/compact_xj_unit.sv
module compact_xj_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_i,
  input  logic [15:0]     instr_i,
  input  logic [XLEN-1:0] rx_val_i,
  input  logic [XLEN-1:0] ra_val_i,
  input  logic [XLEN-1:0] next_pc_i,
  input  logic            mode64_i,
  output logic            wb_en_o,
  output logic [4:0]      wb_idx_o,
  output logic [XLEN-1:0] wb_data_o,
  output logic            ra_we_o,
  output logic [XLEN-1:0] ra_data_o,
  output logic            redir_o,
  output logic [XLEN-1:0] redir_tgt_o,
  output logic            illegal_o
);

  localparam logic [4:0] MAJOR  = 5'b11101;
  localparam logic [4:0] FN_EXT = 5'b10001;
  localparam logic [4:0] FN_JMP = 5'b00000;
  localparam bit         WIDE   = (XLEN > 32);

  wire [2:0] rf  = instr_i[10:8];
  wire [2:0] sub = instr_i[7:5];
  wire [4:0] fn  = instr_i[4:0];
  wire       hit = issue_i && (instr_i[15:11] == MAJOR);

  function automatic logic [XLEN-1:0] widen(input logic [XLEN-1:0] v, input int w, input logic sgn);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++)
      r[i] = (i < w) ? v[i] : (sgn & v[w-1]);
    return r;
  endfunction

  logic            n_wb, n_ra, n_rd, n_ill;
  logic [XLEN-1:0] n_wdat, n_tgt;

  always_comb begin
    n_wb   = 1'b0;
    n_ra   = 1'b0;
    n_rd   = 1'b0;
    n_ill  = 1'b0;
    n_wdat = '0;
    n_tgt  = '0;
    if (hit) begin
      unique case (fn)
        FN_EXT: begin
          unique case (sub)
            3'b000, 3'b100: begin n_wb = 1'b1; n_wdat = widen(rx_val_i, 8,  sub[2]); end
            3'b001, 3'b101: begin n_wb = 1'b1; n_wdat = widen(rx_val_i, 16, sub[2]); end
            3'b010, 3'b110: begin
              if (WIDE && mode64_i) begin
                n_wb   = 1'b1;
                n_wdat = widen(rx_val_i, 32, sub[2]);
              end else begin
                n_ill  = 1'b1;
              end
            end
            default: n_ill = 1'b1;
          endcase
        end
        FN_JMP: begin
          unique case (sub)
            3'b100: begin n_rd = 1'b1; n_tgt = rx_val_i; end
            3'b101: begin
              if (rf == 3'b000) begin n_rd = 1'b1; n_tgt = ra_val_i; end
              else n_ill = 1'b1;
            end
            3'b110: begin n_rd = 1'b1; n_ra = 1'b1; n_tgt = rx_val_i; end
            default: n_ill = 1'b1;
          endcase
        end
        default: n_ill = 1'b1;
      endcase
    end
  end

  wire [4:0] n_idx = (rf[2:1] == 2'b00) ? {4'b1000, rf[0]} : {2'b00, rf};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_en_o     <= 1'b0;
      wb_idx_o    <= '0;
      wb_data_o   <= '0;
      ra_we_o     <= 1'b0;
      ra_data_o   <= '0;
      redir_o     <= 1'b0;
      redir_tgt_o <= '0;
      illegal_o   <= 1'b0;
    end else begin
      wb_en_o     <= n_wb;
      wb_idx_o    <= n_wb ? n_idx : 5'd0;
      wb_data_o   <= n_wdat;
      ra_we_o     <= n_ra;
      ra_data_o   <= n_ra ? next_pc_i : '0;
      redir_o     <= n_rd;
      redir_tgt_o <= n_tgt;
      illegal_o   <= n_ill;
    end
  end

endmodule

// File: rtl/compact_xj_unit_chk.sv
module compact_xj_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_i,
  input logic [15:0]     instr_i,
  input logic [XLEN-1:0] next_pc_i,
  input logic            mode64_i,
  input logic            wb_en_o,
  input logic [4:0]      wb_idx_o,
  input logic [XLEN-1:0] wb_data_o,
  input logic            ra_we_o,
  input logic [XLEN-1:0] ra_data_o,
  input logic            redir_o,
  input logic            illegal_o
);

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !(wb_en_o || ra_we_o || redir_o || illegal_o));

  p_zero_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && instr_i == {5'b11101, instr_i[10:8], 8'b00010001}) |=> (wb_en_o && wb_data_o[XLEN-1:8] == '0));

  p_word_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !mode64_i && instr_i[15:11] == 5'b11101 && instr_i[4:0] == 5'b10001 && instr_i[6:5] == 2'b10)
      |=> (illegal_o && !wb_en_o));

  p_idx_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (wb_idx_o == 5'd16 || wb_idx_o == 5'd17 || (wb_idx_o >= 5'd2 && wb_idx_o <= 5'd7)));

  p_link_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ra_we_o |-> (redir_o && ra_data_o == $past(next_pc_i)));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !(wb_en_o || ra_we_o || redir_o));

  p_one_kind_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_en_o && redir_o));

endmodule

bind compact_xj_unit compact_xj_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
  .next_pc_i(next_pc_i), .mode64_i(mode64_i), .wb_en_o(wb_en_o),
  .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o), .ra_we_o(ra_we_o),
  .ra_data_o(ra_data_o), .redir_o(redir_o), .illegal_o(illegal_o)
);

// File: tb/compact_xj_unit_tb_top.sv
module compact_xj_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [63:0] rx_val_i = '0, ra_val_i = '0, next_pc_i = '0;
  logic        mode64_i = 1'b0;
  logic        wb_en_o, ra_we_o, redir_o, illegal_o;
  logic [4:0]  wb_idx_o;
  logic [63:0] wb_data_o, ra_data_o, redir_tgt_o;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  compact_xj_unit #(.XLEN(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .rx_val_i(rx_val_i), .ra_val_i(ra_val_i), .next_pc_i(next_pc_i),
    .mode64_i(mode64_i), .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o),
    .wb_data_o(wb_data_o), .ra_we_o(ra_we_o), .ra_data_o(ra_data_o),
    .redir_o(redir_o), .redir_tgt_o(redir_tgt_o), .illegal_o(illegal_o)
  );

  function automatic logic [15:0] enc(input logic [2:0] rf, input logic [2:0] sub, input logic [4:0] fn);
    return {5'b11101, rf, sub, fn};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] ins, input logic [63:0] rx, input logic [63:0] ra,
                       input logic [63:0] npc, input logic m64);
    @(negedge clk);
    issue_i = 1'b1; instr_i = ins; rx_val_i = rx; ra_val_i = ra; next_pc_i = npc; mode64_i = m64;
    @(negedge clk);
    issue_i = 1'b0; instr_i = '0;
  endtask

  task automatic expect_out(input string req, input logic we, input logic [4:0] idx, input logic [63:0] d,
                            input logic rwe, input logic [63:0] rd, input logic rv, input logic [63:0] tgt,
                            input logic ill);
    chk({req, " wb_en"}, 64'(wb_en_o), 64'(we));
    if (we) begin
      chk({req, " wb_idx"}, 64'(wb_idx_o), 64'(idx));
      chk({req, " wb_data"}, wb_data_o, d);
    end
    chk({req, " ra_we"}, 64'(ra_we_o), 64'(rwe));
    if (rwe) chk({req, " ra_data"}, ra_data_o, rd);
    chk({req, " redir"}, 64'(redir_o), 64'(rv));
    if (rv) chk({req, " target"}, redir_tgt_o, tgt);
    chk({req, " illegal"}, 64'(illegal_o), 64'(ill));
  endtask

  task automatic expect_idle(input string req);
    chk({req, " idle"}, 64'({wb_en_o, ra_we_o, redir_o, illegal_o}), 64'd0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    expect_idle("R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    expect_idle("R1 after reset");
    chk("R1 wb_data", wb_data_o, 64'd0);
  endtask

  task automatic t_zext;
    issue(enc(3'd2, 3'b000, 5'b10001), 64'hFFFF_FFFF_FFFF_FF85, 0, 0, 1);
    expect_out("R3 zeb", 1, 5'd2, 64'h85, 0, 0, 0, 0, 0);
    issue(enc(3'd3, 3'b001, 5'b10001), 64'h1234_5678_9ABC_F00D, 0, 0, 1);
    expect_out("R3 zeh", 1, 5'd3, 64'hF00D, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sext;
    issue(enc(3'd4, 3'b100, 5'b10001), 64'h0000_0000_0000_1280, 0, 0, 1);
    expect_out("R4 seb neg", 1, 5'd4, 64'hFFFF_FFFF_FFFF_FF80, 0, 0, 0, 0, 0);
    issue(enc(3'd4, 3'b100, 5'b10001), 64'hFFFF_FFFF_FFFF_FF7F, 0, 0, 1);
    expect_out("R4 seb pos", 1, 5'd4, 64'h7F, 0, 0, 0, 0, 0);
    issue(enc(3'd5, 3'b101, 5'b10001), 64'h0000_0000_0001_8001, 0, 0, 0);
    expect_out("R4 seh neg", 1, 5'd5, 64'hFFFF_FFFF_FFFF_8001, 0, 0, 0, 0, 0);
  endtask

  task automatic t_word;
    issue(enc(3'd6, 3'b010, 5'b10001), 64'hFFFF_FFFF_8765_4321, 0, 0, 1);
    expect_out("R5 zew", 1, 5'd6, 64'h0000_0000_8765_4321, 0, 0, 0, 0, 0);
    issue(enc(3'd7, 3'b110, 5'b10001), 64'h0000_0000_8765_4321, 0, 0, 1);
    expect_out("R5 sew neg", 1, 5'd7, 64'hFFFF_FFFF_8765_4321, 0, 0, 0, 0, 0);
    issue(enc(3'd7, 3'b110, 5'b10001), 64'hFFFF_FFFF_7765_4321, 0, 0, 1);
    expect_out("R5 sew pos", 1, 5'd7, 64'h0000_0000_7765_4321, 0, 0, 0, 0, 0);
    issue(enc(3'd6, 3'b010, 5'b10001), 64'h1, 0, 0, 0);
    expect_out("R6 zew mode off", 0, 0, 0, 0, 0, 0, 0, 1);
    issue(enc(3'd6, 3'b110, 5'b10001), 64'h1, 0, 0, 0);
    expect_out("R6 sew mode off", 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_map;
    for (int f = 0; f < 8; f++) begin
      logic [4:0] exp_idx;
      exp_idx = (f == 0) ? 5'd16 : (f == 1) ? 5'd17 : 5'(f);
      issue(enc(3'(f), 3'b000, 5'b10001), 64'(f + 8'h40), 0, 0, 1);
      expect_out("R7 map", 1, exp_idx, 64'(f + 8'h40), 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_jumps;
    issue(enc(3'd3, 3'b100, 5'b00000), 64'h4000_1000, 64'h5000_2000, 64'h6000_3000, 1);
    expect_out("R8 jrc", 0, 0, 0, 0, 0, 1, 64'h4000_1000, 0);
    issue(enc(3'd0, 3'b101, 5'b00000), 64'h4000_1000, 64'h5000_2000, 64'h6000_3000, 1);
    expect_out("R9 jrc ra", 0, 0, 0, 0, 0, 1, 64'h5000_2000, 0);
    issue(enc(3'd1, 3'b110, 5'b00000), 64'h4000_1000, 64'h5000_2000, 64'h6000_3002, 1);
    expect_out("R10 jalrc", 0, 0, 0, 1, 64'h6000_3002, 1, 64'h4000_1000, 0);
  endtask

  task automatic t_illegal;
    issue(enc(3'd2, 3'b101, 5'b00000), 64'h10, 64'h20, 64'h30, 1);
    expect_out("R11 ra jump nonzero field", 0, 0, 0, 0, 0, 0, 0, 1);
    issue(enc(3'd2, 3'b011, 5'b10001), 64'h10, 64'h20, 64'h30, 1);
    expect_out("R11 ext sub 011", 0, 0, 0, 0, 0, 0, 0, 1);
    issue(enc(3'd2, 3'b111, 5'b10001), 64'h10, 64'h20, 64'h30, 1);
    expect_out("R11 ext sub 111", 0, 0, 0, 0, 0, 0, 0, 1);
    issue(enc(3'd2, 3'b000, 5'b00000), 64'h10, 64'h20, 64'h30, 1);
    expect_out("R11 jump sub 000", 0, 0, 0, 0, 0, 0, 0, 1);
    issue(enc(3'd2, 3'b100, 5'b10011), 64'h10, 64'h20, 64'h30, 1);
    expect_out("R11 other funct", 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic t_foreign;
    issue({5'b11100, 3'd2, 3'b100, 5'b00000}, 64'h10, 64'h20, 64'h30, 1);
    expect_idle("R2 foreign major");
    @(negedge clk);
    instr_i = enc(3'd2, 3'b100, 5'b00000);
    rx_val_i = 64'h99;
    @(negedge clk);
    expect_idle("R2 issue low");
    instr_i = '0;
  endtask

  task automatic t_pulse;
    issue(enc(3'd3, 3'b100, 5'b00000), 64'h7000, 0, 0, 1);
    expect_out("R12 first cycle", 0, 0, 0, 0, 0, 1, 64'h7000, 0);
    @(negedge clk);
    expect_idle("R12 second cycle");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_zext();
    t_sext();
    t_word();
    t_map();
    t_jumps();
    t_illegal();
    t_foreign();
    t_pulse();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule